// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a register file split into a fixed global bank and a ring of procedure windows. A movable window pointer picks which window the architectural register numbers point at. Neighbouring windows share part of their storage. When a call moves the pointer forward, the registers the caller used to pass arguments become the callee's first windowed registers. Results the callee leaves in those registers can be seen by the caller once it returns. No data is ever copied.

The file has two combinational read ports and one write port that updates on the clock edge. All three ports use the 5-bit architectural register number. A call strobe moves the pointer forward by one window and a return strobe moves it back by one. The block refuses a call made in the deepest window and a return made in the first window. In either case it raises a one-cycle flag and leaves the pointer where it is.

Top module: `rwin_regfile`

## Requirements
- R1: After reset is released, the window pointer is 0, both flags are low, and every architectural register reads 0.
- R2: Architectural registers 0 to 17 are globals. Each maps to physical entry equal to its number, so it holds the same value whatever the window pointer is.
- R3: In window p, architectural register w (18 to 31) maps to physical entry 18 + ((10*p + w - 18) mod 60). As a result, registers 28..31 of window p are the same storage as registers 18..21 of window p+1, and registers 28..31 of window 5 are the same storage as registers 18..21 of window 0. Registers 22..27 are private to each window.
- R4: A call strobe without a return strobe moves the pointer forward by one at the next clock edge. A return strobe without a call strobe moves it back by one. The pointer always stays within 0 to 5.
- R5: A call made while the pointer is 5 leaves the pointer at 5 and drives the overflow flag high for exactly the following cycle.
- R6: A return made while the pointer is 0 leaves the pointer at 0 and drives the underflow flag high for exactly the following cycle.
- R7: When call and return are strobed in the same cycle, the pointer does not change and neither flag is raised.
- R8: A write in the same cycle as a call or return is decoded with the pointer value from before the move.
- R9: A write takes effect at the clock edge. From the next cycle on, it can be read through every architectural name of that physical entry.
- R10: The two read ports are independent. Each returns the entry selected by its own index through the current pointer, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Move to the next window |
| ret_i | input | 1 | Move back to the previous window |
| rd_a_idx_i | input | 5 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 5 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| we_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Write register number |
| wr_data_i | input | 32 | Write data |
| cwp_o | output | 3 | Current window pointer |
| ovf_o | output | 1 | Refused-call flag |
| unf_o | output | 1 | Refused-return flag |

## Verification
Read data responds in the same cycle, so the bench checks both read ports 1 ns after it drives new indices, before the next edge. The pointer, the overflow flag and the underflow flag each pass through one register, so they are compared at the falling edge that follows the edge where the strobe was sampled. Writes appear at the read ports from the cycle after the write. The behavioural model therefore applies a write at the same edge where the design does, using the pointer value from before that edge's call or return.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned NUM_GLOBAL = 18;
  localparam int unsigned NUM_WIN    = 6;
  localparam int unsigned WIN_REGS   = 14;
  localparam int unsigned OVERLAP    = 4;

  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_PUSH = 2'd1,
    PTR_POP  = 2'd2
  } ptr_act_e;
endpackage

// File: rtl/rwin_ptr.sv
module rwin_ptr
  import rwin_pkg::*;
#(
  parameter int unsigned WINS  = NUM_WIN,
  localparam int unsigned CW_W = $clog2(WINS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            call_i,
  input  logic            ret_i,
  output logic [CW_W-1:0] cwp_o,
  output logic            ovf_o,
  output logic            unf_o
);
  localparam logic [CW_W-1:0] LAST = CW_W'(WINS - 1);

  ptr_act_e         act;
  logic [CW_W-1:0]  cwp_q;
  logic             ovf_q, unf_q;

  always_comb begin
    act = PTR_HOLD;
    if (call_i && !ret_i)      act = PTR_PUSH;
    else if (ret_i && !call_i) act = PTR_POP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      unique case (act)
        PTR_PUSH: if (cwp_q == LAST) ovf_q <= 1'b1; else cwp_q <= cwp_q + 1'b1;
        PTR_POP:  if (cwp_q == '0)   unf_q <= 1'b1; else cwp_q <= cwp_q - 1'b1;
        default:  ;
      endcase
    end
  end

  assign cwp_o = cwp_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  assert_cwp_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwp_q <= LAST);
  assert_push_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && cwp_q != LAST) |=> (cwp_q == $past(cwp_q) + 1'b1) && !ovf_q);
  assert_pop_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && cwp_q != '0) |=> (cwp_q == $past(cwp_q) - 1'b1) && !unf_q);
  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && cwp_q == LAST) |=> ovf_q && $stable(cwp_q));
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && cwp_q == '0) |=> unf_q && $stable(cwp_q));
  assert_both_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && ret_i) |=> $stable(cwp_q) && !ovf_q && !unf_q);
  assert_flag_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_q && unf_q));
endmodule

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
#(
  parameter int unsigned NG    = NUM_GLOBAL,
  parameter int unsigned WINS  = NUM_WIN,
  parameter int unsigned WREGS = WIN_REGS,
  parameter int unsigned OVL   = OVERLAP,
  localparam int unsigned UNIQ   = WREGS - OVL,
  localparam int unsigned RING   = UNIQ * WINS,
  localparam int unsigned DEPTH  = NG + RING,
  localparam int unsigned IDX_W  = $clog2(NG + WREGS),
  localparam int unsigned CW_W   = $clog2(WINS),
  localparam int unsigned PHYS_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CW_W-1:0]   cwp_i,
  output logic [PHYS_W-1:0] phys_o
);
  localparam int unsigned SW = PHYS_W + 1;
  localparam logic [SW-1:0] RING_L = SW'(RING);
  localparam logic [SW-1:0] NG_L   = SW'(NG);
  localparam logic [SW-1:0] UNIQ_L = SW'(UNIQ);

  logic [SW-1:0] base, off, sum, wrapped;

  // ring offset: the single subtraction suffices while OVL <= UNIQ
  always_comb begin
    base    = SW'(cwp_i) * UNIQ_L;
    off     = SW'(idx_i) - NG_L;
    sum     = base + off;
    wrapped = (sum >= RING_L) ? sum - RING_L : sum;
    if (SW'(idx_i) < NG_L) phys_o = PHYS_W'(idx_i);
    else                   phys_o = PHYS_W'(NG_L + wrapped);
  end
endmodule

// File: rtl/rwin_store.sv
module rwin_store
  import rwin_pkg::*;
#(
  parameter int unsigned DEPTH = 78,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned RPORTS = 2,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [RPORTS*AW-1:0]  raddr_i,
  output logic [RPORTS*DW-1:0]  rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < RPORTS; g++) begin : g_rd
    assign rdata_o[g*DW +: DW] = mem_q[raddr_i[g*AW +: AW]];
  end

  assert_write_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned NG    = NUM_GLOBAL,
  parameter int unsigned WINS  = NUM_WIN,
  parameter int unsigned WREGS = WIN_REGS,
  parameter int unsigned OVL   = OVERLAP,
  localparam int unsigned DEPTH  = NG + (WREGS - OVL) * WINS,
  localparam int unsigned IDX_W  = $clog2(NG + WREGS),
  localparam int unsigned CW_W   = $clog2(WINS),
  localparam int unsigned PHYS_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic [DW-1:0]    rd_a_data_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [DW-1:0]    rd_b_data_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [CW_W-1:0]  cwp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam int unsigned NPORT = 3; // two reads, one write

  logic [CW_W-1:0]         cwp;
  logic [NPORT*IDX_W-1:0]  idx_all;
  logic [NPORT*PHYS_W-1:0] phys_all;
  logic [2*DW-1:0]         rdata;

  rwin_ptr #(.WINS(WINS)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .call_i(call_i),
    .ret_i (ret_i),
    .cwp_o (cwp),
    .ovf_o (ovf_o),
    .unf_o (unf_o)
  );

  assign idx_all = {wr_idx_i, rd_b_idx_i, rd_a_idx_i};

  // every port decodes with the pointer before any move at this edge
  for (genvar g = 0; g < NPORT; g++) begin : g_map
    rwin_map #(.NG(NG), .WINS(WINS), .WREGS(WREGS), .OVL(OVL)) u_map (
      .idx_i (idx_all[g*IDX_W +: IDX_W]),
      .cwp_i (cwp),
      .phys_o(phys_all[g*PHYS_W +: PHYS_W])
    );
  end

  rwin_store #(.DEPTH(DEPTH), .DW(DW), .RPORTS(2)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .waddr_i(phys_all[2*PHYS_W +: PHYS_W]),
    .wdata_i(wr_data_i),
    .raddr_i(phys_all[0 +: 2*PHYS_W]),
    .rdata_o(rdata)
  );

  assign rd_a_data_o = rdata[0 +: DW];
  assign rd_b_data_o = rdata[DW +: DW];
  assign cwp_o       = cwp;

  assert_global_alias_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_idx_i < IDX_W'(NG) && !(call_i && ret_i))
      |=> (rd_a_idx_i != $past(wr_idx_i)) || (rd_a_data_o == $past(wr_data_i)));
endmodule

// File: tb/tb_rwin_regfile.sv
`timescale 1ns/1ps
module tb_rwin_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call, ret, we;
  logic [4:0] ra, rb, widx;
  logic [31:0] wdata;
  logic [31:0] rda, rdb;
  logic [2:0] cwp;
  logic ovf, unf;

  int vectors = 0;
  int fails = 0;
  int cwp_m = 0;
  logic ovf_m = 1'b0, unf_m = 1'b0;
  logic [31:0] mem_m [78];

  always #5 clk = ~clk;

  rwin_regfile dut (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .ret_i(ret),
    .rd_a_idx_i(ra), .rd_a_data_o(rda), .rd_b_idx_i(rb), .rd_b_data_o(rdb),
    .we_i(we), .wr_idx_i(widx), .wr_data_i(wdata),
    .cwp_o(cwp), .ovf_o(ovf), .unf_o(unf)
  );

  function automatic int phys(int idx, int p);
    if (idx < 18) return idx;
    return 18 + ((p * 10 + idx - 18) % 60);
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cwp_m=%0d t=%0t)", rq, act, exp, cwp_m, $time);
    end
  endtask

  // called at a falling edge
  task automatic step(input logic c, input logic r, input logic w, input int wi,
                      input logic [31:0] wd, input int a, input int b, input string rq);
    call = c; ret = r; we = w; widx = wi[4:0]; wdata = wd; ra = a[4:0]; rb = b[4:0];
    #1;
    chk(rq, rda, mem_m[phys(a, cwp_m)]);
    chk(rq, rdb, mem_m[phys(b, cwp_m)]);
    @(posedge clk);
    if (w) mem_m[phys(wi, cwp_m)] = wd;  // R8: pre-move pointer
    ovf_m = 1'b0; unf_m = 1'b0;
    if (c && !r) begin
      if (cwp_m == 5) ovf_m = 1'b1; else cwp_m++;
    end else if (r && !c) begin
      if (cwp_m == 0) unf_m = 1'b1; else cwp_m--;
    end
    @(negedge clk);
    chk("R4", {29'd0, cwp}, cwp_m);
    chk("R5", {31'd0, ovf}, {31'd0, ovf_m});
    chk("R6", {31'd0, unf}, {31'd0, unf_m});
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 78; i++) mem_m[i] = '0;
    call = 0; ret = 0; we = 0; widx = 0; wdata = 0; ra = 0; rb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    chk("R1", {29'd0, cwp}, 0);
    chk("R1", {30'd0, ovf, unf}, 0);
    for (int i = 0; i < 32; i++) step(0, 0, 0, 0, 0, i, 31 - i, "R1");
    // R2: globals written in window 0
    for (int i = 0; i < 18; i++) step(0, 0, 1, i, 32'hA000_0000 + i, i, 0, "R2");
    for (int i = 18; i < 32; i++) step(0, 0, 1, i, 32'hB000_0000 + i, i, 17, "R10");
    // R9: freshly written value read back next cycle
    step(0, 0, 1, 25, 32'h1234_5678, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 25, 5, "R9");
    // R8: write with call decodes with old window
    step(1, 0, 1, 28, 32'hC0DE_0001, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 18, 28, "R8");
    step(0, 0, 1, 21, 32'hC0DE_0002, 5, 22, "R3");
    // walk to the deepest window, globals must follow
    for (int k = 0; k < 4; k++) step(1, 0, 1, 29, 32'hD000_0000 + k, k, 19, "R2");
    step(0, 0, 1, 31, 32'hEEEE_0005, 29, 10, "R3");
    // R5: overflow at window 5
    step(1, 0, 0, 0, 0, 28, 31, "R5");
    step(1, 0, 0, 0, 0, 3, 20, "R5");
    // R7: simultaneous strobes
    step(1, 1, 0, 0, 0, 22, 23, "R7");
    // return to window 0; wrapped overlap at window 0
    for (int k = 0; k < 5; k++) step(0, 1, 0, 0, 0, 18, 31, "R3");
    step(0, 0, 0, 0, 0, 21, 19, "R3");
    // R6: underflow at window 0
    step(0, 1, 0, 0, 0, 28, 21, "R6");
    step(0, 1, 1, 30, 32'h0BAD_F00D, 30, 2, "R6");
    step(1, 1, 0, 0, 0, 30, 18, "R7");
    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      int s = $urandom_range(0, 7);
      step(s == 1 || s == 3, s == 2 || s == 3, $urandom_range(0, 1) == 1,
           $urandom_range(0, 31), $urandom, $urandom_range(0, 31),
           $urandom_range(0, 31), "R3/R10");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule